// File: doc/BRIEF.md
# Eight-Lane DDR Word Serializer

This block takes one parallel word per channel for eight channels and turns each word into a serial bit stream on its own lane. Every lane moves in lockstep. The block runs from a single bit clock that is twelve times the sample rate, and each lane sends one bit per bit-clock cycle. Two clocks are produced next to the lanes. The first is a half-rate clock at six times the sample rate: it is high during even bit slots and low during odd ones, so a receiver captures one bit on its rising edge and the next bit on its falling edge. The second is a frame clock at the sample rate, whose rising edge coincides with the first bit of every word.

Samples enter through a valid/ready port. A word of all eight channels is accepted on any bit-clock edge where `in_valid` and `in_ready` are both high. The word waits in a one-entry holding stage and is moved into the lane shifters only at the next frame boundary. While the holding stage is full, `in_ready` stays low and the source must keep `in_valid` and `in_data` stable. Two plain control inputs act at each frame boundary. One chooses the bit order. The other can replace the sample data with a fixed frame pattern or sync pattern on all lanes.

Top module: `ddr_lane_serializer`

## Requirements
- R1: All eight lanes send one 12-bit word every 12 bit-clock cycles, starting together on the same cycle. Lane i carries `in_data[12*i+11:12*i]`.
- R2: `clk6_o` is high in the even bit slots (0, 2, …, 10) and low in the odd ones, so the lane bit changes at every edge of `clk6_o`.
- R3: `frame_o` is high for bit slots 0 to 5 and low for slots 6 to 11. Its rising edge falls in the same cycle as the first bit of a word and as a rising edge of `clk6_o`.
- R4: With `msb_first`=1 a word is sent from bit 11 down to bit 0. With `msb_first`=0 it is sent from bit 0 up to bit 11. The value is sampled at each frame boundary.
- R5: `pat_sel`=2'b01 sends the frame pattern (six 1s, then six 0s) on every lane. `pat_sel`=2'b10 sends the sync pattern (1,0,1,0,… starting with 1). `pat_sel`=2'b00 and 2'b11 both send sample data.
- R6: `in_ready` is high exactly when the holding stage is empty. A word accepted in the middle of a frame is sent starting at the next frame boundary and never within the frame in progress.
- R7: If no word is held at a frame boundary in data mode, every lane sends twelve 0 bits for that frame.
- R8: In a pattern mode, a held word is not consumed and `in_ready` stays low. The word is sent at the first frame boundary after data mode returns.
- R9: While `rst` is high, all lanes, `clk6_o` and `frame_o` are low and `in_ready` is high. The first rising clock edge after `rst` falls is a frame boundary, so slot 0 appears right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 12x the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Source offers a word for all channels |
| in_ready | output | 1 | Holding stage can take a word |
| in_data | input | 96 | Eight 12-bit channel words, channel 0 in the low bits |
| msb_first | input | 1 | 1: most significant bit first; 0: least significant bit first |
| pat_sel | input | 2 | 00/11 data, 01 frame pattern, 10 sync pattern |
| lane_o | output | 8 | Serial data, one bit per channel |
| clk6_o | output | 1 | Half-rate bit clock; both edges carry data |
| frame_o | output | 1 | Frame clock; rising edge marks bit slot 0 |

## Verification
The lanes are driven with distinct per-channel words sent back to back in both bit orders. A mirrored bit order or a swapped lane would produce a different stream under these words. Long idle stretches check that empty frames send zeros, and the two fixed patterns check that a pattern overrides the data on every lane regardless of the bit order. A word offered mid-frame and a word held across a pattern interval separate correct frame-boundary loading from loading too early or consuming the word silently. A behavioural model predicts the lanes, both clocks and `in_ready` on every cycle.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  typedef enum logic [1:0] {
    PAT_DATA  = 2'b00,
    PAT_FRAME = 2'b01,
    PAT_SYNC  = 2'b10,
    PAT_DATA2 = 2'b11
  } pat_e;
endpackage

// File: rtl/ser_timing.sv
`timescale 1ns/1ps
module ser_timing #(
  parameter int WIDTH = 12
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic run_o,
  output logic clk6_o,
  output logic frame_o
);
  localparam int CW = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;

  logic [CW-1:0] slot_q;
  logic          run_q;

  assign load_o = !run_q || (slot_q == CW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      run_q  <= 1'b0;
    end else if (load_o) begin
      slot_q <= '0;
      run_q  <= 1'b1;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign clk6_o  = run_q && !slot_q[0];
  assign frame_o = run_q && (slot_q < CW'(HALF));

  // R9
  run_stays_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  // R3
  frame_on_clk6_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_o) |-> $rose(clk6_o));
endmodule

// File: rtl/ser_ingress.sv
`timescale 1ns/1ps
module ser_ingress #(
  parameter int BITS = 96
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic            data_mode_i,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BITS-1:0] in_data,
  output logic            held_o,
  output logic [BITS-1:0] word_o
);
  logic            full_q;
  logic [BITS-1:0] word_q;
  logic            take;
  logic            accept;

  assign take   = load_i && data_mode_i && full_q;
  assign accept = in_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        word_q <= in_data;
      end else if (take) begin
        full_q <= 1'b0;
      end
    end
  end

  assign in_ready = !full_q;
  assign held_o   = full_q;
  assign word_o   = word_q;

  // R6
  accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R8
  hold_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (full_q && !(load_i && data_mode_i)) |=> (full_q && $stable(word_q)));
endmodule

// File: rtl/ser_lane.sv
`timescale 1ns/1ps
module ser_lane
  import ser_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             msb_first_i,
  input  pat_e             pat_i,
  input  logic             held_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             ser_o
);
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] next_w;
  logic [WIDTH-1:0] frame_pat;
  logic [WIDTH-1:0] sync_pat;
  logic [WIDTH-1:0] rev_w;

  for (genvar b = 0; b < WIDTH; b++) begin : g_pat
    assign frame_pat[b] = (b >= WIDTH / 2);
    assign sync_pat[b]  = ((b % 2) == ((WIDTH - 1) % 2));
    assign rev_w[b]     = word_i[WIDTH - 1 - b];
  end

  always_comb begin
    unique case (pat_i)
      PAT_FRAME: next_w = frame_pat;
      PAT_SYNC:  next_w = sync_pat;
      default:   next_w = held_i ? (msb_first_i ? word_i : rev_w) : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (load_i) sh_q <= next_w;
    else             sh_q <= {sh_q[WIDTH-2:0], 1'b0};
  end

  assign ser_o = run_i && sh_q[WIDTH-1];

  // R5
  frame_first_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && pat_i == PAT_FRAME) |=> ser_o);
endmodule

// File: rtl/ddr_lane_serializer.sv
`timescale 1ns/1ps
module ddr_lane_serializer
  import ser_pkg::*;
#(
  parameter int LANES = 8,
  parameter int WIDTH = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*WIDTH-1:0] in_data,
  input  logic                   msb_first,
  input  logic [1:0]             pat_sel,
  output logic [LANES-1:0]       lane_o,
  output logic                   clk6_o,
  output logic                   frame_o
);
  localparam int BITS = LANES * WIDTH;

  logic            load;
  logic            run;
  logic            held;
  logic            data_mode;
  logic [BITS-1:0] word;
  pat_e            pat;

  assign pat       = pat_e'(pat_sel);
  assign data_mode = (pat == PAT_DATA) || (pat == PAT_DATA2);

  ser_timing #(.WIDTH(WIDTH)) u_timing (
    .clk(clk), .rst(rst), .load_o(load), .run_o(run),
    .clk6_o(clk6_o), .frame_o(frame_o)
  );

  ser_ingress #(.BITS(BITS)) u_ingress (
    .clk(clk), .rst(rst), .load_i(load), .data_mode_i(data_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .held_o(held), .word_o(word)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ser_lane #(.WIDTH(WIDTH)) u_lane (
      .clk(clk), .rst(rst), .load_i(load), .run_i(run),
      .msb_first_i(msb_first), .pat_i(pat), .held_i(held),
      .word_i(word[i*WIDTH +: WIDTH]), .ser_o(lane_o[i])
    );
  end

  // R9
  idle_low_chk: assert property (@(posedge clk)
    rst |=> (lane_o == '0 && !clk6_o && !frame_o));
endmodule

// File: tb/ddr_lane_serializer_test.sv
`timescale 1ns/1ps
module ddr_lane_serializer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [95:0] in_data = '0;
  logic        msb_first = 1'b1;
  logic [1:0]  pat_sel = 2'b00;
  logic [7:0]  lane_o;
  logic        clk6_o;
  logic        frame_o;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R9";

  always #4 clk = ~clk;

  ddr_lane_serializer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .msb_first(msb_first), .pat_sel(pat_sel),
    .lane_o(lane_o), .clk6_o(clk6_o), .frame_o(frame_o)
  );

  // behavioural reference
  bit          m_run = 0;
  int          m_pos = 0;
  logic [11:0] m_cur [8];
  logic [95:0] m_q [$];

  function automatic logic [11:0] flip12(logic [11:0] v);
    logic [11:0] r;
    for (int b = 0; b < 12; b++) r[b] = v[11-b];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_pos = 0; m_q.delete();
      for (int i = 0; i < 8; i++) m_cur[i] = '0;
    end else begin
      bit acc;
      acc = in_valid && (m_q.size() == 0);
      if (!m_run || m_pos == 11) begin
        m_run = 1; m_pos = 0;
        if (pat_sel == 2'b01) begin
          for (int i = 0; i < 8; i++) m_cur[i] = 12'b111111000000;
        end else if (pat_sel == 2'b10) begin
          for (int i = 0; i < 8; i++) m_cur[i] = 12'b101010101010;
        end else if (m_q.size() != 0) begin
          logic [95:0] w;
          w = m_q.pop_front();
          for (int i = 0; i < 8; i++)
            m_cur[i] = msb_first ? w[i*12 +: 12] : flip12(w[i*12 +: 12]);
        end else begin
          for (int i = 0; i < 8; i++) m_cur[i] = '0;
        end
      end else begin
        m_pos++;
      end
      if (acc) m_q.push_back(in_data);
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e_lane;
    for (int i = 0; i < 8; i++) e_lane[i] = m_run ? m_cur[i][11 - m_pos] : 1'b0;
    check(tag, "lanes (R1)", lane_o, e_lane);
    check("R2", "clk6", {7'b0, clk6_o}, {7'b0, m_run && (m_pos % 2 == 0)});
    check("R3", "frame", {7'b0, frame_o}, {7'b0, m_run && (m_pos < 6)});
    check("R6", "ready", {7'b0, in_ready}, {7'b0, m_q.size() == 0});
  end

  function automatic logic [95:0] mk(int k);
    logic [95:0] w;
    for (int i = 0; i < 8; i++) w[i*12 +: 12] = 12'(k * 37 + i * 291 + 5) ^ 12'hA5C;
    return w;
  endfunction

  task automatic push(logic [95:0] w);
    bit r;
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    forever begin
      r = in_ready;
      @(negedge clk);
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    tag = "R9";
    idle(3);
    check("R9", "reset lanes", lane_o, 8'h00);
    check("R9", "reset ready", {7'b0, in_ready}, 8'h01);
    rst = 1'b0;
    tag = "R7";
    idle(26);
    tag = "R1";
    push(mk(1)); push(mk(2)); push(mk(3));
    idle(14);
    tag = "R4";
    msb_first = 1'b0;
    push(mk(4)); push(mk(5));
    idle(14);
    msb_first = 1'b1;
    tag = "R5";
    pat_sel = 2'b01; idle(26);
    pat_sel = 2'b10; msb_first = 1'b0; idle(26);
    msb_first = 1'b1;
    tag = "R8";
    push(mk(6));
    idle(30);
    check("R8", "held word keeps ready low", {7'b0, in_ready}, 8'h00);
    pat_sel = 2'b11;
    idle(30);
    pat_sel = 2'b00;
    tag = "R6";
    idle(5);
    push(mk(7));
    idle(3);
    push(mk(8));
    idle(40);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule